// File: doc/BRIEF.md
# Lane Sync and Alignment-Character Monitor

This block is the receive front end of one serial lane. Every clock it takes a beat of four decoded octets together with a control-character flag, a disparity-error flag and a not-in-table flag for each octet. It works through the beat in time order. First it acquires code group synchronisation from a run of /K/ comma characters. Then it declares frame sync on the first data beat. From there it tracks each octet's position within the frame and the multiframe, using the configured frame length and multiframe length.

Alignment characters (/F/ at frame ends, /A/ at multiframe ends) are checked against the tracked position. A correctly placed one is restored as a data octet by clearing its control flag. A misplaced one, and any other control character seen after frame sync, is reported. A 32-bit counter accumulates the errors that a per-category mask lets through. Software clears this counter explicitly. All outputs are registered, one beat after the input.

Top module: `lane_align_rx`

## Requirements
- R1: The sync state output is 2 bits wide: 0 means not synchronised, 1 means checking and 2 means synchronised; the value 3 never appears. A /K/ is an octet 0xBC with its control flag set, and one /K/ moves the lane out of the not-synchronised state into checking.
- R2: In checking, the fourth consecutive /K/ (counting the one that started the check) moves the lane to synchronised. Any other octet before then returns the lane to not-synchronised. Once synchronised, the lane stays there until it is disabled or reset.
- R3: Octet 0 (bits [7:0]) of a beat is the earliest received and octet 3 (bits [31:24]) is the latest. The sync rules apply to the octets in that order, and the octets leave on `out_data` in the same lanes.
- R4: Frame sync (`fs_ready`) is declared for a beat when the lane was synchronised at the start of that beat and octet 0 of the beat is not a /K/. That octet is position 0 of both the frame and the multiframe. Frame sync then holds until the lane is disabled or reset.
- R5: With replacement enabled (`cfg_repl_dis`=0), a control octet 0xFC (/F/) at the last octet of a frame that does not end a multiframe, or 0x7C (/A/) at the last octet of a frame that ends a multiframe, leaves with its control flag cleared and its byte unchanged, and raises no error.
- R6: With replacement enabled, an /F/ or /A/ at any other position in a frame-synced beat sets `align_err` for that beat and counts as a control error.
- R7: With replacement disabled, every /F/ or /A/ in a frame-synced beat sets `unexp_err`, counts as a control error and keeps its control flag.
- R8: Any other control octet in a frame-synced beat (including /K/) sets `unexp_err` and counts as a control error.
- R9: The frame length is configured as F−1 in `cfg_fm1`, with F one of 1, 2, 4 or 8. The multiframe length is configured as octets-per-multiframe minus 1 in `cfg_kfm1` and must be a multiple of both F and 4.
- R10: In frame-synced beats only, the counter adds one for each octet's control error unless mask bit 0 is set, one for its not-in-table flag unless mask bit 1 is set, and one for its disparity flag unless mask bit 2 is set.
- R11: While `cnt_clear` is high the count becomes 0 on the next clock. Otherwise the count never decreases, and disabling the lane leaves it unchanged.
- R12: With `lane_en` low, the next clock puts the lane in the not-synchronised state, with frame sync low and no errors flagged; its output data is don't-care.
- R13: After reset every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Lane clock |
| rst | input | 1 | Synchronous active-high reset |
| lane_en | input | 1 | Lane enable |
| in_data | input | 32 | Four decoded octets, octet 0 earliest |
| in_ctrl | input | 4 | Control-character flag per octet |
| in_disp_err | input | 4 | Disparity error per octet |
| in_nit_err | input | 4 | Not-in-table error per octet |
| cfg_fm1 | input | 3 | Octets per frame minus 1 |
| cfg_kfm1 | input | 8 | Octets per multiframe minus 1 |
| cfg_repl_dis | input | 1 | 1 disables alignment-character replacement |
| cfg_err_mask | input | 3 | Bit 0 control, bit 1 not-in-table, bit 2 disparity: 1 excludes from count |
| cnt_clear | input | 1 | Clears the error counter |
| out_data | output | 32 | Registered octets |
| out_ctrl | output | 4 | Control flags after replacement |
| cgs_state | output | 2 | Sync state |
| fs_ready | output | 1 | Frame sync reached |
| align_err | output | 1 | Misplaced alignment character in last beat |
| unexp_err | output | 1 | Unexpected control character in last beat |
| err_count | output | 32 | Accumulated error count |

## Verification
The bench aims at the sync walk within a beat. A /K/ run that is broken part-way through a beat must drop the lane back to not-synchronised. A design that processed octets from the top byte down, or that tested only whole beats, would report checking or synchronised instead. Alignment characters are placed one octet early or late across several frame and multiframe sizes, including F=1, where every octet ends a frame. An off-by-one position counter, or a frame-end test that ignored the multiframe boundary, would flip an /F/ into an accepted /A/ and miss the error. Mask bits, counter clear and lane disable are exercised while errors keep arriving. A counter that cleared on disable, or that counted before frame sync, would drift from the reference count.

// File: rtl/lane_align_pkg.sv
package lane_align_pkg;
  typedef enum logic [1:0] {
    CGS_INIT  = 2'd0,
    CGS_CHECK = 2'd1,
    CGS_DATA  = 2'd2
  } cgs_e;

  localparam logic [7:0] SYM_K = 8'hBC;
  localparam logic [7:0] SYM_F = 8'hFC;
  localparam logic [7:0] SYM_A = 8'h7C;
endpackage

// File: rtl/lane_cgs_fsm.sv
module lane_cgs_fsm import lane_align_pkg::*; #(
  parameter int NUM_OCT = 4,
  parameter int K_RUN   = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               lane_en,
  input  logic [NUM_OCT-1:0] is_k,
  output cgs_e               state_q,
  output logic               fs_q,
  output logic               fs_start
);
  localparam int KC_W = $clog2(K_RUN + 1);

  logic [KC_W-1:0] kcnt_q, kc;
  cgs_e            st;

  // walk octets in arrival order, lowest first
  always_comb begin
    st = state_q;
    kc = kcnt_q;
    for (int i = 0; i < NUM_OCT; i++) begin
      case (st)
        CGS_INIT: if (is_k[i]) begin
          st = CGS_CHECK;
          kc = KC_W'(1);
        end
        CGS_CHECK: if (is_k[i]) begin
          kc = kc + KC_W'(1);
          if (kc == KC_W'(K_RUN)) st = CGS_DATA;
        end else begin
          st = CGS_INIT;
          kc = '0;
        end
        default: ;
      endcase
    end
  end

  assign fs_start = lane_en && (state_q == CGS_DATA) && !fs_q && !is_k[0];

  always_ff @(posedge clk) begin
    if (rst || !lane_en) begin
      state_q <= CGS_INIT;
      kcnt_q  <= '0;
      fs_q    <= 1'b0;
    end else begin
      state_q <= st;
      kcnt_q  <= kc;
      fs_q    <= fs_q | fs_start;
    end
  end

  p_legal_state_r1: assert property (@(posedge clk) disable iff (rst)
    state_q inside {CGS_INIT, CGS_CHECK, CGS_DATA});
  p_fs_needs_data_r4: assert property (@(posedge clk) disable iff (rst)
    fs_q |-> state_q == CGS_DATA);
  p_disabled_init_r12: assert property (@(posedge clk) disable iff (rst)
    !lane_en |=> (state_q == CGS_INIT) && !fs_q);
  p_data_sticky_r2: assert property (@(posedge clk) disable iff (rst)
    (state_q == CGS_DATA) && lane_en |=> state_q == CGS_DATA);
endmodule

// File: rtl/lane_frame_tracker.sv
module lane_frame_tracker import lane_align_pkg::*; #(
  parameter int NUM_OCT = 4,
  parameter int POS_W   = 8,
  parameter int FW      = 3
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 lane_en,
  input  logic                 active,
  input  logic                 restart,
  input  logic [FW-1:0]        cfg_fm1,
  input  logic [POS_W-1:0]     cfg_kfm1,
  input  logic                 cfg_repl_dis,
  input  logic [NUM_OCT*8-1:0] data,
  input  logic [NUM_OCT-1:0]   ctrl,
  output logic [NUM_OCT-1:0]   misalign,
  output logic [NUM_OCT-1:0]   unexp,
  output logic [NUM_OCT-1:0]   replaced
);
  logic [POS_W-1:0] pos_q, pos_end;
  logic [POS_W-1:0] pos_oct [NUM_OCT];

  always_comb begin
    logic [POS_W-1:0] p;
    p = restart ? '0 : pos_q;
    for (int i = 0; i < NUM_OCT; i++) begin
      pos_oct[i] = p;
      p = (p == cfg_kfm1) ? '0 : p + POS_W'(1);
    end
    pos_end = p;
  end

  for (genvar g = 0; g < NUM_OCT; g++) begin : g_oct
    logic [7:0] byte_v;
    logic is_a, is_f, f_end, mf_end, placed_ok, repl_on;
    assign byte_v    = data[8*g +: 8];
    assign is_a      = ctrl[g] && (byte_v == SYM_A);
    assign is_f      = ctrl[g] && (byte_v == SYM_F);
    assign f_end     = (pos_oct[g][FW-1:0] & cfg_fm1) == cfg_fm1;
    assign mf_end    = pos_oct[g] == cfg_kfm1;
    assign placed_ok = (is_a && f_end && mf_end) || (is_f && f_end && !mf_end);
    assign repl_on   = active && !cfg_repl_dis;
    assign replaced[g] = repl_on && placed_ok;
    assign misalign[g] = repl_on && (is_a || is_f) && !placed_ok;
    assign unexp[g]    = active && ctrl[g] && !(!cfg_repl_dis && (is_a || is_f));
  end

  always_ff @(posedge clk) begin
    if (rst || !lane_en) pos_q <= '0;
    else                 pos_q <= active ? pos_end : '0;
  end

  p_repl_excl_r6: assert property (@(posedge clk) disable iff (rst)
    (replaced & misalign) == '0);
  p_idle_pos_r4: assert property (@(posedge clk) disable iff (rst)
    !active |=> pos_q == '0);
  p_no_flags_idle_r12: assert property (@(posedge clk) disable iff (rst)
    !active |-> (misalign | unexp | replaced) == '0);
endmodule

// File: rtl/lane_err_counter.sv
module lane_err_counter #(
  parameter int NUM_OCT = 4,
  parameter int CNT_W   = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               clear,
  input  logic [2:0]         mask,
  input  logic [NUM_OCT-1:0] ctrl_err,
  input  logic [NUM_OCT-1:0] nit_err,
  input  logic [NUM_OCT-1:0] disp_err,
  output logic [CNT_W-1:0]   cnt_q
);
  localparam int MAX_STEP = 3 * NUM_OCT;
  localparam int SUM_W    = $clog2(MAX_STEP + 1);

  logic [SUM_W-1:0] sum;

  always_comb begin
    sum = '0;
    for (int i = 0; i < NUM_OCT; i++) begin
      sum = sum + SUM_W'(ctrl_err[i] & ~mask[0])
                + SUM_W'(nit_err[i]  & ~mask[1])
                + SUM_W'(disp_err[i] & ~mask[2]);
    end
  end

  always_ff @(posedge clk) begin
    if (rst || clear) cnt_q <= '0;
    else              cnt_q <= cnt_q + CNT_W'(sum);
  end

  p_clear_zero_r11: assert property (@(posedge clk) disable iff (rst)
    clear |=> cnt_q == '0);
  p_step_bound_r10: assert property (@(posedge clk) disable iff (rst)
    !clear |=> (cnt_q - $past(cnt_q)) <= CNT_W'(MAX_STEP));
endmodule

// File: rtl/lane_align_rx.sv
module lane_align_rx import lane_align_pkg::*; #(
  parameter int NUM_OCT = 4,
  parameter int POS_W   = 8,
  parameter int FW      = 3,
  parameter int CNT_W   = 32,
  parameter int K_RUN   = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 lane_en,
  input  logic [NUM_OCT*8-1:0] in_data,
  input  logic [NUM_OCT-1:0]   in_ctrl,
  input  logic [NUM_OCT-1:0]   in_disp_err,
  input  logic [NUM_OCT-1:0]   in_nit_err,
  input  logic [FW-1:0]        cfg_fm1,
  input  logic [POS_W-1:0]     cfg_kfm1,
  input  logic                 cfg_repl_dis,
  input  logic [2:0]           cfg_err_mask,
  input  logic                 cnt_clear,
  output logic [NUM_OCT*8-1:0] out_data,
  output logic [NUM_OCT-1:0]   out_ctrl,
  output logic [1:0]           cgs_state,
  output logic                 fs_ready,
  output logic                 align_err,
  output logic                 unexp_err,
  output logic [CNT_W-1:0]     err_count
);
  logic [NUM_OCT-1:0] is_k, misalign, unexp, replaced;
  cgs_e state_q;
  logic fs_q, fs_start, active;

  for (genvar g = 0; g < NUM_OCT; g++) begin : g_kdet
    assign is_k[g] = in_ctrl[g] && (in_data[8*g +: 8] == SYM_K);
  end

  lane_cgs_fsm #(.NUM_OCT(NUM_OCT), .K_RUN(K_RUN)) u_cgs (
    .clk(clk), .rst(rst), .lane_en(lane_en), .is_k(is_k),
    .state_q(state_q), .fs_q(fs_q), .fs_start(fs_start)
  );

  assign active = lane_en && (fs_q || fs_start);

  lane_frame_tracker #(.NUM_OCT(NUM_OCT), .POS_W(POS_W), .FW(FW)) u_trk (
    .clk(clk), .rst(rst), .lane_en(lane_en), .active(active),
    .restart(fs_start), .cfg_fm1(cfg_fm1), .cfg_kfm1(cfg_kfm1),
    .cfg_repl_dis(cfg_repl_dis), .data(in_data), .ctrl(in_ctrl),
    .misalign(misalign), .unexp(unexp), .replaced(replaced)
  );

  lane_err_counter #(.NUM_OCT(NUM_OCT), .CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .clear(cnt_clear), .mask(cfg_err_mask),
    .ctrl_err(misalign | unexp),
    .nit_err(in_nit_err & {NUM_OCT{active}}),
    .disp_err(in_disp_err & {NUM_OCT{active}}),
    .cnt_q(err_count)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_data  <= '0;
      out_ctrl  <= '0;
      align_err <= 1'b0;
      unexp_err <= 1'b0;
    end else begin
      out_data  <= in_data;
      out_ctrl  <= in_ctrl & ~replaced;
      align_err <= |misalign;
      unexp_err <= |unexp;
    end
  end

  assign cgs_state = state_q;
  assign fs_ready  = fs_q;

  p_err_needs_sync_r6: assert property (@(posedge clk) disable iff (rst)
    (align_err || unexp_err) |-> fs_ready);
  p_repl_only_clears_r5: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (out_ctrl & ~$past(in_ctrl)) == '0);
endmodule

// File: tb/lane_align_rx_bench.sv
`timescale 1ns/1ps
module lane_align_rx_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        lane_en = 1'b0;
  logic [31:0] in_data = '0;
  logic [3:0]  in_ctrl = '0, in_disp = '0, in_nit = '0;
  logic [2:0]  cfg_fm1 = 3'd3;
  logic [7:0]  cfg_kfm1 = 8'd15;
  logic        repl_dis = 1'b0;
  logic [2:0]  mask = '0;
  logic        cnt_clear = 1'b0;

  logic [31:0] out_data, err_count;
  logic [3:0]  out_ctrl;
  logic [1:0]  cgs_state;
  logic        fs_ready, align_err, unexp_err;

  int checks = 0, errors = 0;
  bit done = 0, seen = 0;

  always #10 clk = ~clk;

  lane_align_rx u_lane_align_rx (
    .clk(clk), .rst(rst), .lane_en(lane_en), .in_data(in_data), .in_ctrl(in_ctrl),
    .in_disp_err(in_disp), .in_nit_err(in_nit), .cfg_fm1(cfg_fm1), .cfg_kfm1(cfg_kfm1),
    .cfg_repl_dis(repl_dis), .cfg_err_mask(mask), .cnt_clear(cnt_clear),
    .out_data(out_data), .out_ctrl(out_ctrl), .cgs_state(cgs_state), .fs_ready(fs_ready),
    .align_err(align_err), .unexp_err(unexp_err), .err_count(err_count)
  );

  // behavioural reference model
  int m_state, m_kc, m_pos, f_len, kf_len, add;
  bit m_fs, m_aln, m_unx, act, start, fe, me, isa, isf, isk, cerr, c;
  logic [31:0] m_data, m_cnt;
  logic [3:0]  m_ctrl;
  logic [7:0]  b;

  always @(posedge clk) begin
    seen = 1;
    if (rst) begin
      m_state = 0; m_kc = 0; m_fs = 0; m_pos = 0; m_cnt = 0;
      m_data = 0; m_ctrl = 0; m_aln = 0; m_unx = 0;
    end else begin
      f_len = int'(cfg_fm1) + 1; kf_len = int'(cfg_kfm1) + 1; add = 0;
      m_data = in_data; m_ctrl = in_ctrl; m_aln = 0; m_unx = 0;
      if (!lane_en) begin
        m_state = 0; m_kc = 0; m_fs = 0; m_pos = 0;
      end else begin
        start = (m_state == 2) && !m_fs && !(in_ctrl[0] && in_data[7:0] == 8'hBC);
        act = m_fs || start;
        if (start) m_pos = 0;
        for (int i = 0; i < 4; i++) begin
          b = in_data[8*i +: 8]; c = in_ctrl[i]; isk = c && b == 8'hBC;
          if (m_state == 0) begin
            if (isk) begin m_state = 1; m_kc = 1; end
          end else if (m_state == 1) begin
            if (isk) begin m_kc++; if (m_kc == 4) m_state = 2; end
            else begin m_state = 0; m_kc = 0; end
          end
          if (act) begin
            fe = ((m_pos + 1) % f_len) == 0;
            me = ((m_pos + 1) % kf_len) == 0;
            isa = c && b == 8'h7C; isf = c && b == 8'hFC; cerr = 0;
            if (!repl_dis && (isa || isf)) begin
              if ((isa && fe && me) || (isf && fe && !me)) m_ctrl[i] = 1'b0;
              else begin m_aln = 1; cerr = 1; end
            end else if (c) begin
              m_unx = 1; cerr = 1;
            end
            if (cerr && !mask[0]) add++;
            if (in_nit[i] && !mask[1]) add++;
            if (in_disp[i] && !mask[2]) add++;
            m_pos = (m_pos + 1) % kf_len;
          end
        end
        if (act) m_fs = 1;
      end
      if (cnt_clear) m_cnt = 0; else m_cnt = m_cnt + 32'(add);
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act_v, input logic [31:0] exp_v);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act_v, exp_v, $time);
    end
  endtask

  // per-clock comparison against the model
  always @(negedge clk) begin
    if (seen && !done) begin
      chk(cgs_state == 2'(m_state), "R1/R2 sync state", 32'(cgs_state), 32'(m_state));
      chk(fs_ready == m_fs, "R4 frame sync", 32'(fs_ready), 32'(m_fs));
      chk(out_data == m_data, "R3 data order", out_data, m_data);
      chk(out_ctrl == m_ctrl, "R5/R7 ctrl flags", 32'(out_ctrl), 32'(m_ctrl));
      chk(align_err == m_aln, "R6 misalignment", 32'(align_err), 32'(m_aln));
      chk(unexp_err == m_unx, "R7/R8 unexpected ctrl", 32'(unexp_err), 32'(m_unx));
      chk(err_count == m_cnt, "R10 error count", err_count, m_cnt);
    end
  end

  task automatic beat(input logic [31:0] d, input logic [3:0] cf,
                      input logic [3:0] ne = 4'h0, input logic [3:0] de = 4'h0);
    in_data = d; in_ctrl = cf; in_nit = ne; in_disp = de;
    @(negedge clk);
  endtask

  task automatic rand_run(input logic [2:0] fm1, input logic [7:0] kfm1, input int n);
    logic [31:0] d; logic [3:0] cf, ne, de; int r, p;
    lane_en = 1'b0; beat(32'h0, 4'h0);
    cfg_fm1 = fm1; cfg_kfm1 = kfm1; lane_en = 1'b1;
    beat(32'hBCBCBCBC, 4'hF); beat(32'hBCBCBCBC, 4'hF);
    for (int k = 0; k < n; k++) begin
      d = $urandom; cf = '0;
      for (int i = 0; i < 4; i++) begin
        r = int'($urandom % 40);
        p = (m_pos + i) % (int'(kfm1) + 1);
        if (m_fs && ((p + 1) % (int'(fm1) + 1)) == 0 && r < 12) begin
          d[8*i +: 8] = (((p + 1) % (int'(kfm1) + 1)) == 0) ? 8'h7C : 8'hFC; cf[i] = 1'b1;
        end else if (r == 12) begin d[8*i +: 8] = 8'hFC; cf[i] = 1'b1; end
        else if (r == 13) begin d[8*i +: 8] = 8'h7C; cf[i] = 1'b1; end
        else if (r == 14) begin d[8*i +: 8] = 8'hBC; cf[i] = 1'b1; end
        else if (r == 15) begin d[8*i +: 8] = 8'h1C; cf[i] = 1'b1; end
      end
      ne = 4'($urandom) & 4'($urandom) & 4'($urandom);
      de = 4'($urandom) & 4'($urandom) & 4'($urandom);
      if (k % 16 == 0) mask = 3'($urandom);
      if (k % 23 == 0) repl_dis = ($urandom % 4) == 0;
      cnt_clear = ($urandom % 40) == 0;
      beat(d, cf, ne, de);
    end
    cnt_clear = 1'b0; repl_dis = 1'b0; mask = '0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R13: reset values
    chk(cgs_state == 2'd0 && !fs_ready && !align_err && !unexp_err, "R13 reset flags", 32'(cgs_state), 32'h0);
    chk(err_count == 0 && out_data == 0 && out_ctrl == 0, "R13 reset data", err_count, 32'h0);
    rst = 1'b0; lane_en = 1'b1;
    beat(32'hBC332211, 4'h8);
    chk(cgs_state == 2'd1, "R1 enter check", 32'(cgs_state), 32'd1);
    beat(32'h5544BCBC, 4'h3);
    chk(cgs_state == 2'd0, "R2 broken run", 32'(cgs_state), 32'd0);
    beat(32'h66BCBCBC, 4'h7);
    chk(cgs_state == 2'd0, "R3 octet order", 32'(cgs_state), 32'd0);
    beat(32'hBCBCBCBC, 4'hF);
    chk(cgs_state == 2'd2 && !fs_ready, "R2 synced", 32'(cgs_state), 32'd2);
    beat(32'hBCBCBCBC, 4'hF);
    chk(!fs_ready, "R4 no sync on K", 32'(fs_ready), 32'd0);
    beat(32'hFC020100, 4'h8);
    chk(fs_ready && out_ctrl == 4'h0 && !align_err, "R5 F replaced", 32'(out_ctrl), 32'h0);
    beat(32'h7C060504, 4'h8);
    chk(align_err && err_count == 1, "R6 A at frame end", err_count, 32'd1);
    beat(32'h0B0AFC08, 4'h2);
    chk(align_err && err_count == 2, "R6 F mid frame", err_count, 32'd2);
    beat(32'h7C0E0D0C, 4'h8);
    chk(!align_err && out_ctrl == 4'h0 && out_data == 32'h7C0E0D0C, "R5 A replaced", 32'(out_ctrl), 32'h0);
    beat(32'h03BC0100, 4'h4);
    chk(unexp_err && err_count == 3, "R8 K after sync", err_count, 32'd3);
    repl_dis = 1'b1;
    beat(32'hFC020100, 4'h8);
    chk(unexp_err && !align_err && out_ctrl == 4'h8 && err_count == 4, "R7 repl disabled", err_count, 32'd4);
    repl_dis = 1'b0; mask = 3'b010;
    beat(32'h07060504, 4'h0, 4'hF, 4'h1);
    chk(err_count == 5, "R10 nit masked", err_count, 32'd5);
    mask = 3'b000;
    lane_en = 1'b0;
    beat(32'h0, 4'h0, 4'hF, 4'hF);
    chk(cgs_state == 2'd0 && !fs_ready && err_count == 5, "R12 disable", err_count, 32'd5);
    cnt_clear = 1'b1; lane_en = 1'b1;
    beat(32'h0, 4'h0);
    chk(err_count == 0, "R11 clear", err_count, 32'd0);
    cnt_clear = 1'b0;
    beat(32'h0, 4'h0, 4'hF, 4'hF);
    chk(err_count == 0 && !fs_ready, "R10 not counted unsynced", err_count, 32'd0);
    // R9: F=2, K*F=8
    lane_en = 1'b0; beat(32'h0, 4'h0);
    cfg_fm1 = 3'd1; cfg_kfm1 = 8'd7; lane_en = 1'b1;
    beat(32'hBCBCBCBC, 4'hF);
    beat(32'hFC00FC00, 4'hA);
    chk(fs_ready && !align_err && out_ctrl == 4'h0, "R9 F=2 frame ends", 32'(out_ctrl), 32'h0);
    beat(32'h7C00FC00, 4'hA);
    chk(!align_err && out_ctrl == 4'h0, "R9 F=2 multiframe end", 32'(out_ctrl), 32'h0);
    beat(32'hFC00FC00, 4'hA);
    rand_run(3'd0, 8'd7, 80);
    rand_run(3'd1, 8'd7, 80);
    rand_run(3'd3, 8'd15, 80);
    rand_run(3'd7, 8'd31, 80);
    rand_run(3'd7, 8'd15, 80);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1; checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule